// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Core

This block is a cycle model of a synchronous static memory with separate read and write ports. A read command and a write command can each be issued in every clock cycle. Every transfer is a burst of two beats of `DATA_W` bits. Inside, the memory is one word of `2*DATA_W` bits per address, so the address carries one bit less than a count of single beats would need. The two transfer edges of a double-rate bus are modelled as two ordered beat slots in each cycle.

A write command gives only the address. Its two data beats come one cycle later on the write beat slots. The block gathers both beats into one array word and stores it in a single write at the end of that data cycle. A read command fetches one array word, which moves through a fixed pipeline and appears on the read beat slots three cycles after the command. An output valid flag travels alongside it.

Both data paths are valid-only streams and have no back-pressure. The block accepts a command on every cycle its valid is high, and the consumer of read data must take each burst in the single cycle its valid is high. When read valid is low, the read beat slots carry zero.

Top module: `b2sram_core`

## Requirements
- R1: While reset is held and on the first cycle after it, `rd_out_valid` is 0. After reset, every address reads back as all zeros until it is written.
- R2: A read command sampled at the clock edge that ends cycle T makes `rd_out_valid` 1 in cycle T+3. `rd_out_valid` is 1 in no other cycle, and both beat slots are zero whenever it is 0.
- R3: Beat order is fixed. Write slot 0 is stored in bits `[DATA_W-1:0]` of the array word and write slot 1 in bits `[2*DATA_W-1:DATA_W]`. A read returns the low half on `rd_out_beat0` and the high half on `rd_out_beat1`.
- R4: The write beats are sampled in the cycle after the write command. Both beats are stored together at the end of that cycle.
- R5: A read command and a write command issued in the same cycle are both accepted, whatever their addresses.
- R6: A read of address A issued in the same cycle as a write command to A, or in the cycle after it, returns the contents A held before that write. A read issued two or more cycles after the command returns the new word.
- R7: Read commands on consecutive cycles produce bursts on consecutive cycles, in command order, with no gap or stall.
- R8: Values on the write beat slots are ignored in any cycle that does not follow a write command, and they change no array word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_cmd_valid | input | 1 | Read command present this cycle |
| rd_cmd_addr | input | ADDR_W | Read word address |
| wr_cmd_valid | input | 1 | Write command present this cycle |
| wr_cmd_addr | input | ADDR_W | Write word address |
| wr_beat0 | input | DATA_W | First write beat slot, sampled the cycle after a write command |
| wr_beat1 | input | DATA_W | Second write beat slot, sampled the cycle after a write command |
| rd_out_valid | output | 1 | Read burst present this cycle |
| rd_out_beat0 | output | DATA_W | First read beat slot (low half of word) |
| rd_out_beat1 | output | DATA_W | Second read beat slot (high half of word) |

## Verification
The hardest situation to create is a read of an address whose write is still in flight. This happens when the read is issued in the same cycle as the write command or in the next cycle, while the new beats have not yet been stored. The random phase confines addresses to a handful of words and issues reads and writes at high rates, so these overlaps occur many times. Directed sequences also place a write, a same-cycle read, a next-cycle read and a later read to one address, so the switch from old to new data is checked at an exact cycle.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;
  localparam int unsigned DEF_DATA_W = 18;
  localparam int unsigned DEF_ADDR_W = 6;
  localparam int unsigned RD_LATENCY = 3;
  localparam int unsigned BURST_LEN  = 2;
endpackage

// File: rtl/b2_wr_gather.sv
module b2_wr_gather #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] beat0,
  input  logic [DATA_W-1:0] beat1,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WORD_W-1:0] commit_word
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= cmd_valid;
      if (cmd_valid) addr_q <= cmd_addr;
    end
  end

  // Beats are taken from the cycle after the command; slot 0 is the low half.
  assign commit_en   = pend_q;
  assign commit_addr = addr_q;
  assign commit_word = {beat1, beat0};

  // R4: a write command leads to a commit in the next cycle
  assert_commit_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> commit_en);
  // R8: no commit without a preceding command
  assert_no_stray_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !commit_en);
endmodule

// File: rtl/b2_word_array.sv
module b2_word_array #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic              rd_hit,
  output logic [WORD_W-1:0] rd_word,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [WORD_W-1:0] wd
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  // Registered read; it sees the contents from before a commit on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hit  <= 1'b0;
      rd_word <= '0;
    end else begin
      rd_hit  <= re;
      rd_word <= re ? mem[ra] : '0;
    end
  end

  // R4: a committed word is present at its address on the following cycle
  assert_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(wa)] == $past(wd));
endmodule

// File: rtl/b2_rd_pipe.sv
module b2_rd_pipe #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  logic              v_q [STAGES+1];
  logic [WORD_W-1:0] d_q [STAGES+1];

  assign v_q[0] = in_valid;
  assign d_q[0] = in_word;

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        d_q[s] <= '0;
      end else begin
        v_q[s] <= v_q[s-1];
        d_q[s] <= v_q[s-1] ? d_q[s-1] : '0;
      end
    end
  end

  assign out_valid = v_q[STAGES];
  assign out_word  = d_q[STAGES];

  // R2: idle output slots carry zero
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_word == '0);
endmodule

// File: rtl/b2sram_core.sv
module b2sram_core
  import b2sram_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned WORD_W = BURST_LEN * DATA_W,
  localparam int unsigned PIPE_STAGES = RD_LATENCY - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd_valid,
  input  logic [ADDR_W-1:0] rd_cmd_addr,
  input  logic              wr_cmd_valid,
  input  logic [ADDR_W-1:0] wr_cmd_addr,
  input  logic [DATA_W-1:0] wr_beat0,
  input  logic [DATA_W-1:0] wr_beat1,
  output logic              rd_out_valid,
  output logic [DATA_W-1:0] rd_out_beat0,
  output logic [DATA_W-1:0] rd_out_beat1
);
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [WORD_W-1:0] cm_word;
  logic              arr_hit;
  logic [WORD_W-1:0] arr_word;
  logic [WORD_W-1:0] out_word;

  b2_wr_gather #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_gather (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(wr_cmd_valid), .cmd_addr(wr_cmd_addr),
    .beat0(wr_beat0), .beat1(wr_beat1),
    .commit_en(cm_en), .commit_addr(cm_addr), .commit_word(cm_word)
  );

  b2_word_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .re(rd_cmd_valid), .ra(rd_cmd_addr),
    .rd_hit(arr_hit), .rd_word(arr_word),
    .we(cm_en), .wa(cm_addr), .wd(cm_word)
  );

  b2_rd_pipe #(.WORD_W(WORD_W), .STAGES(PIPE_STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(arr_hit), .in_word(arr_word),
    .out_valid(rd_out_valid), .out_word(out_word)
  );

  // Output mux: low half is the first beat, high half the second.
  assign rd_out_beat0 = out_word[DATA_W-1:0];
  assign rd_out_beat1 = out_word[WORD_W-1:DATA_W];

  // Edges since reset, saturating at the latency, to guard the $past window.
  logic [1:0] since_rst_q;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  // R2: read valid follows the command by exactly three cycles
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q == 2'd3) |-> rd_out_valid == $past(rd_cmd_valid, 3));
  // R1: reset clears the output flag
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !rd_out_valid);
endmodule

// File: tb/test_b2sram_core.sv
module test_b2sram_core;
  localparam int DW = 18;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_cmd_valid = 1'b0, wr_cmd_valid = 1'b0;
  logic [AW-1:0] rd_cmd_addr = '0, wr_cmd_addr = '0;
  logic [DW-1:0] wr_beat0 = '0, wr_beat1 = '0;
  logic rd_out_valid;
  logic [DW-1:0] rd_out_beat0, rd_out_beat1;

  b2sram_core #(.DATA_W(DW), .ADDR_W(AW)) i_b2sram_core (
    .clk(clk), .rst_n(rst_n),
    .rd_cmd_valid(rd_cmd_valid), .rd_cmd_addr(rd_cmd_addr),
    .wr_cmd_valid(wr_cmd_valid), .wr_cmd_addr(wr_cmd_addr),
    .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
    .rd_out_valid(rd_out_valid), .rd_out_beat0(rd_out_beat0),
    .rd_out_beat1(rd_out_beat1)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model
  logic [2*DW-1:0] mdl_mem [DEPTH];
  logic            mp_v [3];
  logic [2*DW-1:0] mp_d [3];
  logic            m_pend;
  logic [AW-1:0]   m_paddr;

  function automatic logic [2*DW-1:0] pack_beats(logic [DW-1:0] b0, logic [DW-1:0] b1);
    return {b1, b0};
  endfunction

  task automatic check(string tag, logic [2*DW:0] act, logic [2*DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '0;
    for (int i = 0; i < 3; i++) begin mp_v[i] = 1'b0; mp_d[i] = '0; end
    m_pend = 1'b0;
    m_paddr = '0;
  endtask

  // One cycle: drive, clock, update model, compare outputs.
  task automatic cyc(bit rv, logic [AW-1:0] ra, bit wv, logic [AW-1:0] wa,
                     logic [DW-1:0] b0, logic [DW-1:0] b1, string tag);
    logic [2*DW-1:0] rword;
    rd_cmd_valid = rv; rd_cmd_addr = ra;
    wr_cmd_valid = wv; wr_cmd_addr = wa;
    wr_beat0 = b0; wr_beat1 = b1;
    @(posedge clk);
    rword = rv ? mdl_mem[ra] : '0;
    mp_v[2] = mp_v[1]; mp_d[2] = mp_d[1];
    mp_v[1] = mp_v[0]; mp_d[1] = mp_d[0];
    mp_v[0] = rv;      mp_d[0] = rword;
    if (m_pend) mdl_mem[m_paddr] = pack_beats(b0, b1);
    m_pend = wv;
    if (wv) m_paddr = wa;
    #1;
    check(tag, {rd_out_valid, rd_out_beat1, rd_out_beat0}, {mp_v[2], mp_d[2]});
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, '0, '0, tag);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", {rd_out_valid, rd_out_beat1, rd_out_beat0}, '0);
    rst_n = 1'b1;
    // R1: fresh array reads zero
    for (int a = 0; a < 8; a++) cyc(1, a[AW-1:0], 0, '0, 18'h3ffff, 18'h3ffff, "R1 zero after reset");
    idle(3, "R1 drain");

    // R3/R4: distinct beats, ordered halves
    cyc(0, '0, 1, 6'd5, '0, '0, "R4 cmd");
    cyc(0, '0, 0, '0, 18'h0aaaa, 18'h15555, "R4 beats");
    cyc(1, 6'd5, 0, '0, '0, '0, "R3 read order");
    idle(3, "R3 drain");
    check("R3 beat0 low half", {1'b0, 18'd0, rd_out_beat0}, '0);

    // R6: write to 9 with same-cycle, next-cycle and later reads
    cyc(0, '0, 1, 6'd9, '0, '0, "R6 seed cmd");
    cyc(0, '0, 0, '0, 18'h00111, 18'h00222, "R6 seed beats");
    cyc(1, 6'd9, 1, 6'd9, '0, '0, "R6 same cycle read");
    cyc(1, 6'd9, 0, '0, 18'h00333, 18'h00444, "R6 next cycle read");
    cyc(1, 6'd9, 0, '0, '0, '0, "R6 later read");
    idle(3, "R6 drain");

    // R5: read and write together, different addresses
    cyc(1, 6'd5, 1, 6'd20, '0, '0, "R5 dual issue");
    cyc(1, 6'd20, 0, '0, 18'h12345, 18'h2abcd, "R5 dual beats");
    cyc(1, 6'd20, 0, '0, '0, '0, "R5 read back");
    idle(3, "R5 drain");

    // R8: beats without a pending write are ignored
    cyc(0, '0, 0, '0, 18'h3ffff, 18'h3ffff, "R8 stray beats");
    cyc(0, '0, 0, '0, 18'h1f0f0, 18'h0f0f0, "R8 stray beats");
    cyc(1, 6'd20, 0, '0, '0, '0, "R8 word unchanged");
    cyc(1, 6'd30, 0, '0, '0, '0, "R8 unwritten stays zero");
    idle(3, "R8 drain");

    // R7: back-to-back reads, no stall
    for (int a = 0; a < 6; a++) cyc(1, a[AW-1:0] + 6'd4, 0, '0, '0, '0, "R7 streaming");
    idle(3, "R7 drain");

    // Random traffic over few addresses to force overlap (R2, R6)
    for (int i = 0; i < 3000; i++) begin
      cyc(bit'($urandom_range(0, 3) != 0), AW'($urandom_range(0, 3)),
          bit'($urandom_range(0, 2) != 0), AW'($urandom_range(0, 3)),
          DW'($urandom), DW'($urandom), "R2 random traffic");
    end
    idle(4, "R2 final drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule